// File: doc/BRIEF.md
# ADSR Envelope Generator

This block shapes the loudness of one sound voice. It takes a gate bit and four 4-bit settings (attack rate, decay rate, sustain level and release rate) and produces an 8-bit envelope level. When the gate rises, the level climbs one step at a time to full scale. It then falls to a sustain level that software selects. When the gate drops, it falls toward zero. The output port can be read back at any time.

A free-running 16-bit prescaler sets the time between envelope steps. The 4-bit rate setting of the active phase picks one of sixteen fixed periods. Gate edges never clear the prescaler, so the first step after an edge arrives after a delay that depends on its phase. While the level is falling, a second divider stretches the steps by a ratio that changes at fixed levels, which gives a piece-wise exponential curve. A single-cycle clock enable paces all timing. Software writes three registers through a one-cycle write strobe.

Top module: `adsr_env`

## Requirements
- R1: After reset the level is 0 and the block is in the release phase with the index-0 period and the zero lock set. With no rising gate edge the level stays at 0.
- R2: In the active phase the prescaler selects a period by rate index 0..15: 9, 32, 63, 95, 149, 220, 267, 313, 392, 977, 1954, 3126, 3907, 11720, 19532, 31251 enabled cycles. Each time the prescaler reaches that period it restarts from 0 and gives one tick. Every envelope step moves the level by exactly one. Two steps are never less than 9 enabled cycles apart.
- R3: While the clock enable is low, nothing advances and the level holds. Timing counts enabled cycles only.
- R4: In attack the level rises by one per tick. On reaching 255 the block enters the decay/sustain phase. There it falls until the level equals the sustain nibble copied into both halves of a byte (S=5 gives 0x55), and then it holds.
- R5: While falling (decay or release) a step happens only every Nth tick. N becomes 1, 2, 4, 8, 16, 30 and 1 when a step brings the level to 255, 93, 54, 26, 14, 6 and 0 respectively, and otherwise N is kept. Attack ignores N. With A=D=1 and S=0, the span from the step to level 1 up to the step to level 0 is 1010 ticks of 32 cycles (32320 cycles). The complete envelope, including the step from 0 to 1, is 32352 cycles.
- R6: A step to level 0 in decay or release sets the zero lock. No further step happens until a rising gate edge.
- R7: A falling gate edge enters release, using the release nibble's period and the ratio N already in force.
- R8: A rising gate edge enters attack from the current level and clears the zero lock.
- R9: A write to the rate nibble of the active phase changes the period used for the next tick at once.
- R10: Gate edges do not clear the prescaler. After reset with index 0, a gate rise written on the 13th enabled edge yields level 1 five cycles later.
- R11: Register select 0 is control (bit 0 = gate). Select 1 holds attack in bits 7:4 and decay in bits 3:0. Select 2 holds sustain in bits 7:4 and release in bits 3:0. A write takes effect at the clock edge where wr_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce | input | 1 | Single-cycle clock enable that paces all envelope timing |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 control, 1 attack/decay, 2 sustain/release) |
| wr_data | input | 8 | Write data |
| level | output | 8 | Current envelope level |

## Verification
The bench goes after the prescaler phase. A design that cleared the prescaler on a gate edge would produce the first attack step after nine cycles instead of five. A design that sampled the rate only on phase changes would ignore a live rate write and keep the old period. The falling-curve breakpoints are timed one by one, so a ratio loaded one level late shows up as a wrong segment length. Two more faults are caught: a missing zero lock lets release wrap from 0 to 255, and an enable that is not honoured gives nine-cycle steps when the enable alternates.

// File: rtl/adsr_env.sv
module adsr_env #(
  parameter int RATE_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] level
);
  localparam int EXP_W = 5;
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_AD   = 2'd1;
  localparam logic [1:0] SEL_SR   = 2'd2;

  typedef enum logic [1:0] {ST_ATK = 2'd0, ST_DS = 2'd1, ST_REL = 2'd2} st_e;

  st_e               state_q;
  logic              gate_q, hold_q;
  logic [3:0]        atk_q, dec_q, sus_q, rel_q;
  logic [3:0]        rate_sel;
  logic [RATE_W-1:0] rate_q, rate_inc, period;
  logic [EXP_W-1:0]  exp_q, exp_inc, exp_per_q, exp_per_nx;
  logic [7:0]        env_q, env_nx;
  logic              tick, exp_hit, step;

  always_comb begin
    case (state_q)
      ST_ATK:  rate_sel = atk_q;
      ST_DS:   rate_sel = dec_q;
      default: rate_sel = rel_q;
    endcase
  end

  always_comb begin
    case (rate_sel)
      4'd0:    period = RATE_W'(9);
      4'd1:    period = RATE_W'(32);
      4'd2:    period = RATE_W'(63);
      4'd3:    period = RATE_W'(95);
      4'd4:    period = RATE_W'(149);
      4'd5:    period = RATE_W'(220);
      4'd6:    period = RATE_W'(267);
      4'd7:    period = RATE_W'(313);
      4'd8:    period = RATE_W'(392);
      4'd9:    period = RATE_W'(977);
      4'd10:   period = RATE_W'(1954);
      4'd11:   period = RATE_W'(3126);
      4'd12:   period = RATE_W'(3907);
      4'd13:   period = RATE_W'(11720);
      4'd14:   period = RATE_W'(19532);
      default: period = RATE_W'(31251);
    endcase
  end

  assign rate_inc = rate_q + RATE_W'(1);
  assign tick     = ce && (rate_inc == period);
  assign exp_inc  = exp_q + EXP_W'(1);
  assign exp_hit  = (state_q == ST_ATK) || (exp_inc == exp_per_q);
  assign step     = tick && exp_hit && !hold_q;
  assign level    = env_q;

  always_comb begin
    case (state_q)
      ST_ATK:  env_nx = env_q + 8'd1;
      ST_DS:   env_nx = (env_q == {sus_q, sus_q}) ? env_q : env_q - 8'd1;
      default: env_nx = env_q - 8'd1;
    endcase
  end

  always_comb begin
    case (env_nx)
      8'd255:  exp_per_nx = EXP_W'(1);
      8'd93:   exp_per_nx = EXP_W'(2);
      8'd54:   exp_per_nx = EXP_W'(4);
      8'd26:   exp_per_nx = EXP_W'(8);
      8'd14:   exp_per_nx = EXP_W'(16);
      8'd6:    exp_per_nx = EXP_W'(30);
      8'd0:    exp_per_nx = EXP_W'(1);
      default: exp_per_nx = exp_per_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_REL;
      gate_q    <= 1'b0;
      hold_q    <= 1'b1;
      atk_q     <= '0;
      dec_q     <= '0;
      sus_q     <= '0;
      rel_q     <= '0;
      rate_q    <= '0;
      exp_q     <= '0;
      exp_per_q <= EXP_W'(1);
      env_q     <= '0;
    end else begin
      if (ce)
        rate_q <= tick ? '0 : rate_inc;
      if (tick)
        exp_q <= exp_hit ? '0 : exp_inc;
      if (step) begin
        env_q     <= env_nx;
        exp_per_q <= exp_per_nx;
        if (env_nx == 8'd0)
          hold_q <= 1'b1;
        if (state_q == ST_ATK && env_nx == 8'hFF)
          state_q <= ST_DS;
      end
      if (wr_en) begin
        case (wr_sel)
          SEL_CTRL: begin
            gate_q <= wr_data[0];
            if (!gate_q && wr_data[0]) begin
              state_q <= ST_ATK;
              hold_q  <= 1'b0;
            end else if (gate_q && !wr_data[0]) begin
              state_q <= ST_REL;
            end
          end
          SEL_AD: begin
            atk_q <= wr_data[7:4];
            dec_q <= wr_data[3:0];
          end
          SEL_SR: begin
            sus_q <= wr_data[7:4];
            rel_q <= wr_data[3:0];
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/adsr_env_chk.sv
module adsr_env_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ce,
  input logic [7:0] level,
  input logic       hold_q,
  input logic [1:0] state_q,
  input logic [3:0] sus_q
);
  localparam logic [1:0] DS_CODE = 2'd1;

  logic [7:0] lv_d;
  logic [3:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lv_d <= '0;
      gap  <= 4'd15;
    end else begin
      lv_d <= level;
      if (level != lv_d)
        gap <= ce ? 4'd1 : 4'd0;
      else if (ce && gap != 4'd15)
        gap <= gap + 4'd1;
    end
  end

  // R3
  ce_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(level));

  // R2
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($stable(level) || level == $past(level) + 8'd1 || level == $past(level) - 8'd1));

  // R2
  min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level != lv_d) |-> (gap >= 4'd9));

  // R6
  zero_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |=> $stable(level));

  // R4
  sustain_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == DS_CODE && level == {sus_q, sus_q}) |=> $stable(level));
endmodule

bind adsr_env adsr_env_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .ce     (ce),
  .level  (level),
  .hold_q (hold_q),
  .state_q(state_q),
  .sus_q  (sus_q)
);

// File: tb/sim_adsr_env.sv
module sim_adsr_env;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] level;

  int checks = 0;
  int fails = 0;
  bit half = 1'b0;

  localparam logic [19:0] RATE_VEC [6] = '{
    {4'd0, 16'd9}, {4'd1, 16'd32}, {4'd2, 16'd63},
    {4'd3, 16'd95}, {4'd5, 16'd220}, {4'd9, 16'd977}
  };

  adsr_env u0 (
    .clk(clk), .rst_n(rst_n), .ce(ce), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .level(level)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic tick_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ce = 1'b1; wr_en = 1'b0; half = 1'b0;
    tick_n(3);
    rst_n = 1'b1;
  endtask

  task automatic wait_change(output int n);
    logic [7:0] s;
    s = level;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (half) ce = ~ce;
    end while (level == s);
  endtask

  task automatic wait_level(input logic [7:0] v);
    while (level != v) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n, t, t93, t92, t6, t5, t255;
    bit seen;

    @(negedge clk);
    do_reset();
    chk(level == 8'd0, "R1 level after reset", level, 0);
    tick_n(100);
    chk(level == 8'd0, "R1 level idle without gate", level, 0);

    for (int i = 0; i < 6; i++) begin
      logic [3:0] idx;
      int per;
      idx = RATE_VEC[i][19:16];
      per = int'(RATE_VEC[i][15:0]);
      do_reset();
      wr(2'd2, 8'h00);
      wr(2'd1, {idx, 4'h0});
      wr(2'd0, 8'h01);
      wait_change(n);
      wait_change(n);
      chk(n == per, "R2 attack step period", n, per);
    end

    // R10: writes land on enabled edges 1, 2 and 13; ticks fall on 9, 18
    do_reset();
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h00);
    tick_n(10);
    wr(2'd0, 8'h01);
    wait_change(n);
    chk(n == 5, "R10 first step delay after gate rise", n, 5);

    // R3: enable alternates starting high, so 9 enabled edges span 17 cycles
    half = 1'b1;
    wait_change(n);
    half = 1'b0;
    ce = 1'b1;
    chk(n == 17, "R3 step spacing with half-rate enable", n, 17);
    ce = 1'b0;
    begin
      logic [7:0] s;
      s = level;
      tick_n(50);
      chk(level == s, "R3 level frozen while enable low", level, s);
    end
    ce = 1'b1;

    // R5: A=0 D=0 S=0, times from the cycle level reads 255
    do_reset();
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h01);
    wait_level(8'd255);
    t = 0; t93 = -1; t92 = -1; t6 = -1; t5 = -1;
    while (level != 8'd0) begin
      @(negedge clk);
      t++;
      if (level == 8'd93 && t93 < 0) t93 = t;
      if (level == 8'd92 && t92 < 0) t92 = t;
      if (level == 8'd6 && t6 < 0) t6 = t;
      if (level == 8'd5 && t5 < 0) t5 = t;
    end
    chk(t93 == 1458, "R5 unit-ratio segment 255 to 93", t93, 1458);
    chk(t92 - t93 == 18, "R5 ratio 2 after 93", t92 - t93, 18);
    chk(t5 - t6 == 270, "R5 ratio 30 after 6", t5 - t6, 270);
    chk(t == 6804, "R5 decay 255 to 0 total", t, 6804);

    // R4, R7, R9, R6, R8
    do_reset();
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h50);
    wr(2'd0, 8'h01);
    wait_level(8'd255);
    chk(level == 8'd255, "R4 attack peak", level, 255);
    wait_level(8'h55);
    tick_n(300);
    chk(level == 8'h55, "R4 sustain hold at doubled nibble", level, 85);
    chk(level == 8'h55, "R11 sustain taken from bits 7:4", level, 85);
    wr(2'd2, 8'h52);
    wr(2'd0, 8'h00);
    wait_change(n);
    wait_change(n);
    chk(n == 126, "R7 release gap with ratio 2 and period 63", n, 126);
    wr(2'd2, 8'h50);
    wait_change(n);
    chk(n + 1 == 18, "R9 live release rate rewrite", n + 1, 18);
    wait_level(8'd0);
    tick_n(1000);
    chk(level == 8'd0, "R6 zero lock in release", level, 0);
    wr(2'd0, 8'h01);
    wait_change(n);
    chk(level == 8'd1 && n <= 9, "R8 new attack from zero", level, 1);

    // R5: A=D=R=1 S=0
    do_reset();
    wr(2'd1, 8'h11);
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h01);
    wait_level(8'd1);
    t = 0; t255 = -1; seen = 1'b0;
    while (!(seen && level == 8'd0)) begin
      @(negedge clk);
      t++;
      if (level == 8'd255 && !seen) begin
        seen = 1'b1;
        t255 = t;
      end
    end
    chk(t255 == 8128, "R5 attack 1 to 255 at period 32", t255, 8128);
    chk(t == 32320, "R5 level 1 to level 0 span", t, 32320);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule